// File: doc/BRIEF.md
# Burst Address Counter with Load

This block generates the address for one port of a synchronous memory. Each cycle it picks one address for the current access. When the strobe is low it passes the external address straight through, in the same cycle. Otherwise it presents the value held in an internal counter.

On every rising clock edge the counter does one of four things: it clears, loads the external address, steps by one, or keeps its value. Three active-low controls choose the action, with a fixed priority among them. A host can therefore strobe in a start address and then let the counter walk through successive words without driving the address bus again.

The counter spans the whole address space and rolls over from the top address to zero. A separate synchronous power-on reset also clears it. The address width is a parameter, for example 15, 16 or 17 bits for 32K, 64K or 128K words.

Top module: `burst_addr_gen`

## Requirements
- R1: When `cntClrN` is low at a rising edge, the counter becomes 0 after that edge. This holds even if `strobeN` and `countEnN` are also low at that edge.
- R2: In a cycle where `cntClrN` is low, `curAddr` still shows the address of the current access (the external address or the counter), so a read or write can use it in that cycle.
- R3: When `cntClrN` is high and `strobeN` is low at a rising edge, the counter takes the value of `extAddr`. This holds whatever the state of `countEnN`.
- R4: When `cntClrN` and `strobeN` are high and `countEnN` is low at a rising edge, the counter goes up by one.
- R5: When `cntClrN`, `strobeN` and `countEnN` are all high at a rising edge, the counter keeps its value and `extAddr` has no effect on it.
- R6: A step from the top address (2^ADDR_W - 1) gives 0.
- R7: `curAddr` equals `extAddr` while `strobeN` is low, and equals the counter value while `strobeN` is high. The selection is combinational, with no cycle of delay.
- R8: When `rst` is high at a rising edge, the counter becomes 0 after that edge, whatever the state of `cntClrN` and the other controls.
- R9: A cycle that strobes in address A shows A on `curAddr`. Then, with `strobeN` high and `countEnN` low, the following cycles show A, A+1, A+2 and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst | input | 1 | Synchronous power-on reset, active high |
| extAddr | input | ADDR_W | External address |
| strobeN | input | 1 | Address strobe, active low: use and load `extAddr` |
| countEnN | input | 1 | Count enable, active low |
| cntClrN | input | 1 | Counter clear, active low, highest priority |
| curAddr | output | ADDR_W | Address used for the current access |

## Verification
The bench builds the block with ADDR_W set to 4. This makes the rollover from 15 to 0 reachable within a short run of steps, and lets random external addresses hit both the top and bottom addresses often. A random phase mixes all control combinations so that every priority pairing occurs. A behavioural model checks the pass-through address in each cycle as well as the counter value after each edge.

// File: rtl/burst_addr_pkg.sv
`timescale 1ns/1ps
package burst_addr_pkg;
  // One-hot-ish strobes from control decode to the datapath
  typedef struct packed {
    logic clear;    // force counter to zero
    logic load;     // take external address
    logic step;     // advance by one
    logic passExt;  // present external address this cycle
  } addrCtl_t;
endpackage

// File: rtl/burst_addr_ctrl.sv
`timescale 1ns/1ps
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic     rst,
  input  logic     strobeN,
  input  logic     countEnN,
  input  logic     cntClrN,
  output addrCtl_t ctl
);
  // Fixed priority: power-on / clear > load > step > hold
  always_comb begin
    ctl         = '0;
    ctl.passExt = ~strobeN;
    if (rst || !cntClrN) begin
      ctl.clear = 1'b1;
    end else if (!strobeN) begin
      ctl.load = 1'b1;
    end else if (!countEnN) begin
      ctl.step = 1'b1;
    end
  end
endmodule

// File: rtl/burst_addr_dp.sv
`timescale 1ns/1ps
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  addrCtl_t          ctl,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] cntVal,
  output logic [ADDR_W-1:0] curAddr
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] cntQ;
  logic [ADDR_W-1:0] cntInc;

  // Natural modulo-2^ADDR_W rollover
  assign cntInc = cntQ + ONE;

  always_ff @(posedge clk) begin
    if (ctl.clear)     cntQ <= '0;
    else if (ctl.load) cntQ <= extAddr;
    else if (ctl.step) cntQ <= cntInc;
  end

  assign cntVal  = cntQ;
  assign curAddr = ctl.passExt ? extAddr : cntQ;
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              strobeN,
  input  logic              countEnN,
  input  logic              cntClrN,
  output logic [ADDR_W-1:0] curAddr
);
  addrCtl_t          ctl;
  logic [ADDR_W-1:0] cntVal;

  burst_addr_ctrl u_ctrl (
    .rst      (rst),
    .strobeN  (strobeN),
    .countEnN (countEnN),
    .cntClrN  (cntClrN),
    .ctl      (ctl)
  );

  burst_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .ctl     (ctl),
    .extAddr (extAddr),
    .cntVal  (cntVal),
    .curAddr (curAddr)
  );
endmodule

// File: rtl/burst_addr_chk.sv
`timescale 1ns/1ps
module burst_addr_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] extAddr,
  input logic              strobeN,
  input logic              countEnN,
  input logic              cntClrN,
  input logic [ADDR_W-1:0] cntVal,
  input logic [ADDR_W-1:0] curAddr
);
  // R8
  a_r8_por_clear: assert property (@(posedge clk) rst |=> cntVal == '0);

  // R1
  a_r1_clear_wins: assert property (@(posedge clk) disable iff (rst)
    !cntClrN |=> cntVal == '0);

  // R3
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (cntClrN && !strobeN) |=> cntVal == $past(extAddr));

  // R4 / R6
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (cntClrN && strobeN && !countEnN) |=> cntVal == ADDR_W'($past(cntVal) + 1'b1));

  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (cntClrN && strobeN && countEnN) |=> $stable(cntVal));

  // R7
  a_r7_pass_ext: assert property (@(posedge clk) disable iff (rst)
    !strobeN |-> curAddr == extAddr);
  a_r7_show_cnt: assert property (@(posedge clk) disable iff (rst)
    strobeN |-> curAddr == cntVal);
endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .extAddr  (extAddr),
  .strobeN  (strobeN),
  .countEnN (countEnN),
  .cntClrN  (cntClrN),
  .cntVal   (cntVal),
  .curAddr  (curAddr)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
  localparam int W    = 4;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] extAddr;
  logic         strobeN, countEnN, cntClrN;
  logic [W-1:0] curAddr;

  int  nVec  = 0;
  int  nFail = 0;
  int  refCnt = 0;
  bit  done  = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) u_dut (
    .clk(clk), .rst(rst), .extAddr(extAddr), .strobeN(strobeN),
    .countEnN(countEnN), .cntClrN(cntClrN), .curAddr(curAddr)
  );

  // Drive one cycle, compare the address seen in it, then advance the model at the edge
  task automatic step(input string tag, input bit r, input int a,
                      input bit s, input bit c, input bit k);
    int expect_v;
    @(negedge clk);
    rst = r; extAddr = W'(a); strobeN = s; countEnN = c; cntClrN = k;
    #2;
    expect_v = (!s) ? (a % SPAN) : refCnt;
    nVec++;
    if (int'(curAddr) != expect_v) begin
      nFail++;
      $display("FAIL %s: curAddr=%0d expected=%0d", tag, curAddr, expect_v);
    end
    @(posedge clk);
    if (r || !k)      refCnt = 0;
    else if (!s)      refCnt = a % SPAN;
    else if (!c)      refCnt = (refCnt + 1) % SPAN;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1; extAddr = '0; strobeN = 1; countEnN = 1; cntClrN = 1;
    repeat (2) @(posedge clk);
    refCnt = 0;
    // R8: after power-on reset the counter reads 0
    step("R8", 0, 9, 1, 1, 1);
    // R3 / R7 / R9: strobe in 5, then count
    step("R7", 0, 5, 0, 1, 1);
    step("R9", 0, 12, 1, 0, 1);
    step("R9", 0, 12, 1, 0, 1);
    step("R9", 0, 3, 1, 0, 1);
    // R5: hold with a changing external address
    step("R5", 0, 1, 1, 1, 1);
    step("R5", 0, 14, 1, 1, 1);
    step("R5", 0, 0, 1, 1, 1);
    // R3: load beats count enable
    step("R3", 0, 14, 0, 0, 1);
    step("R6", 0, 2, 1, 0, 1);
    step("R6", 0, 2, 1, 0, 1);   // shows 15, rolls to 0
    step("R6", 0, 2, 1, 1, 1);   // shows 0
    // R1 / R2: clear beats load and count; access address still correct
    step("R4", 0, 7, 0, 1, 1);
    step("R2", 0, 11, 0, 0, 0);  // strobe low: sees 11, clear wins
    step("R1", 0, 11, 1, 1, 1);  // counter 0
    step("R4", 0, 0, 1, 0, 1);
    step("R2", 0, 0, 1, 1, 0);   // strobe high during clear: shows 1
    step("R1", 0, 6, 1, 1, 1);
    // R8: power-on reset independent of clear input
    step("R4", 0, 10, 0, 1, 1);
    step("R8", 1, 4, 0, 0, 1);
    step("R8", 0, 4, 1, 1, 1);
    // R6 long count to rollover
    step("R3", 0, 13, 0, 1, 1);
    for (int i = 0; i < 6; i++) step("R6", 0, 0, 1, 0, 1);
    // mixed random phase
    for (int i = 0; i < 400; i++) begin
      int a;
      bit s, c, k;
      a = int'($urandom_range(SPAN - 1, 0));
      s = ($urandom_range(3, 0) == 0) ? 1'b0 : 1'b1;
      c = ($urandom_range(2, 0) == 0) ? 1'b1 : 1'b0;
      k = ($urandom_range(9, 0) == 0) ? 1'b0 : 1'b1;
      step(!k ? "R1" : (!s ? "R3" : (!c ? "R4" : "R5")), 0, a, s, c, k);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule